// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block holds a 15-bit enable mask and a 15-bit pending-request word. It turns the requests that are both pending and enabled into a 3-bit processor priority level from 1 to 6. Each word is written with its own strobe in a set/clear format. Bit 15 of the write data picks the action: 1 sets the selected bits and 0 clears them. Bits 14..0 are the select mask. Each word is read back on its own port.

Requests come from three kinds of source:
- Peripherals raise requests with single-cycle pulses.
- Two active-low external lines raise requests on their falling edges. One line maps to level 2 and the other to level 6.
- Software can force any request through the write port. It uses the same format to clear a request once it has been serviced.

Enable bit 14 is a master gate. It is never a request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: On an `ena_wr` cycle, the enable bits selected by a 1 in `wdata[14:0]` are set when `wdata[15]`=1 and cleared when `wdata[15]`=0. Unselected bits keep their value. Without `ena_wr` the enable word does not change.
- R2: On a `req_wr` cycle, the request bits 13..0 selected in `wdata[13:0]` are set when `wdata[15]`=1 and cleared when it is 0. Unselected requests keep their value. The result is visible on `req_q` after the next clock edge.
- R3: Enable bit 14 is the master enable. While it is 0, `irq_level` is 0. Request bit 14 always reads 0, even after a write that selects it.
- R4: Request bit n maps to a level as follows: bits 0..2 to level 1, bit 3 to level 2, bits 4..6 to level 3, bits 7..10 to level 4, bits 11..12 to level 5, and bit 13 to level 6.
- R5: With the master enable set, `irq_level` is the highest level among the bits that are both requested and enabled, and 0 if there are none. It follows the registers combinationally.
- R6: A falling edge on `ext_hi_n` sets request bit 13 on the third rising clock edge after the line is first sampled low. A line held low sets the bit only once, so after a clear the bit stays 0 until the line rises and falls again.
- R7: A falling edge on `ext_lo_n` sets request bit 3 with the same timing and once-only behaviour as R6.
- R8: A 1 on `src_pulse[n]` sets request bit n at the next edge. If a software clear of the same bit occurs in the same cycle, the set wins.
- R9: Bit 15 of `ena_q` and bit 15 of `req_q` always read 0.
- R10: After reset, both words are 0 and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena_wr | input | 1 | Write strobe for the enable word |
| req_wr | input | 1 | Write strobe for the request word |
| wdata | input | 16 | Write data: bit 15 selects set or clear, bits 14..0 select the bits |
| src_pulse | input | 14 | Peripheral request pulses, one per request bit 13..0 |
| ext_hi_n | input | 1 | Active-low external line for the high level (bit 13) |
| ext_lo_n | input | 1 | Active-low external line for the low level (bit 3) |
| ena_q | output | 16 | Enable word read-back, bit 15 is 0 |
| req_q | output | 16 | Request word read-back, bit 15 is 0 |
| irq_level | output | 3 | Encoded priority level, 0 when nothing is active |

## Verification
The hardest case to reach is a conflict on one request bit in a single cycle, where a peripheral pulse and a software clear arrive together. The bench drives both in the same low clock phase and reads the bit back on the next phase.

A second hard case is an external line held low across a software clear. The bench holds the line low, clears the bit, and waits several cycles to show the bit stays 0. It then releases the line and lowers it again to show the next edge sets the bit. Level encoding is swept over every single enabled bit and every pair of requested bits.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ena_wr,
  input  logic        req_wr,
  input  logic [15:0] wdata,
  input  logic [13:0] src_pulse,
  input  logic        ext_hi_n,
  input  logic        ext_lo_n,
  output logic [15:0] ena_q,
  output logic [15:0] req_q,
  output logic [2:0]  irq_level
);
  localparam int NB = 15;

  logic [NB-1:0] en_r, req_r, hw_set, sw_set, sw_clr;
  logic [2:0]    hi_s, lo_s;
  logic          hi_fall, lo_fall;
  logic [13:0]   active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_s <= 3'b111;
      lo_s <= 3'b111;
    end else begin
      hi_s <= {hi_s[1:0], ext_hi_n};
      lo_s <= {lo_s[1:0], ext_lo_n};
    end

  assign hi_fall = hi_s[2] & ~hi_s[1];
  assign lo_fall = lo_s[2] & ~lo_s[1];

  assign hw_set = {1'b0, src_pulse[13] | hi_fall, src_pulse[12:4],
                   src_pulse[3] | lo_fall, src_pulse[2:0]};
  assign sw_set = (req_wr &&  wdata[15]) ? wdata[NB-1:0] : '0;
  assign sw_clr = (req_wr && !wdata[15]) ? wdata[NB-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_r  <= '0;
      req_r <= '0;
    end else begin
      if (ena_wr)
        en_r <= wdata[15] ? (en_r | wdata[NB-1:0]) : (en_r & ~wdata[NB-1:0]);
      req_r <= ((req_r & ~sw_clr) | sw_set | hw_set) & 15'h3FFF;
    end

  assign active = req_r[13:0] & en_r[13:0] & {14{en_r[14]}};

  always_comb begin
    if (active[13])           irq_level = 3'd6;
    else if (|active[12:11])  irq_level = 3'd5;
    else if (|active[10:7])   irq_level = 3'd4;
    else if (|active[6:4])    irq_level = 3'd3;
    else if (active[3])       irq_level = 3'd2;
    else if (|active[2:0])    irq_level = 3'd1;
    else                      irq_level = 3'd0;
  end

  assign ena_q = {1'b0, en_r};
  assign req_q = {1'b0, req_r};
endmodule

module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ena_wr,
  input logic        req_wr,
  input logic [15:0] wdata,
  input logic [13:0] src_pulse,
  input logic [15:0] ena_q,
  input logic [15:0] req_q,
  input logic [2:0]  irq_level
);
  a_r1_set_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && wdata[15]) |=> ((ena_q[14:0] & $past(wdata[14:0])) == $past(wdata[14:0])));
  a_r1_clr_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && !wdata[15]) |=> ((ena_q[14:0] & $past(wdata[14:0])) == 15'd0));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_wr |=> $stable(ena_q));
  a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_q[14] |-> irq_level == 3'd0);
  a_r3_no_req14: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[14] == 1'b0);
  a_r5_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level <= 3'd6);
  a_r8_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((req_q[13:0] & $past(src_pulse)) == $past(src_pulse)));
  a_r9_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q[15] == 1'b0) && (req_q[15] == 1'b0));
  a_r2_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && wdata[15]) |=> ((req_q[13:0] & $past(wdata[13:0])) == $past(wdata[13:0])));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ena_wr(ena_wr), .req_wr(req_wr), .wdata(wdata),
  .src_pulse(src_pulse), .ena_q(ena_q), .req_q(req_q), .irq_level(irq_level)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic        clk = 0, rst_n = 0, ena_wr = 0, req_wr = 0;
  logic [15:0] wdata = 0;
  logic [13:0] src_pulse = 0;
  logic        ext_hi_n = 1, ext_lo_n = 1;
  logic [15:0] ena_q, req_q;
  logic [2:0]  irq_level;
  int total = 0, bad = 0;
  bit done = 0;

  irq_prio_ctrl uut (.*);

  always #5 clk = ~clk;

  function automatic int lvl(int b);
    if (b <= 2) return 1;
    if (b == 3) return 2;
    if (b <= 6) return 3;
    if (b <= 10) return 4;
    if (b <= 12) return 5;
    return 6;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(bit to_req, logic [15:0] d);
    @(negedge clk);
    wdata = d;
    if (to_req) req_wr = 1; else ena_wr = 1;
    @(negedge clk);
    req_wr = 0; ena_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf, en_m;
    idle(2);
    // R10 reset state
    chk("R10 ena", ena_q, 0);
    chk("R10 req", req_q, 0);
    chk("R10 lvl", irq_level, 0);
    rst_n = 1;
    idle(2);

    // R1 set/clear sweep with model; R9 top bit
    lf = 16'hACE1; en_m = 0;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wr(0, lf);
      if (lf[15]) en_m[14:0] = en_m[14:0] | lf[14:0];
      else        en_m[14:0] = en_m[14:0] & ~lf[14:0];
      chk("R1 enable word", ena_q, {1'b0, en_m[14:0]});
      chk("R9 ena bit15", ena_q[15], 0);
    end
    // R1 request write does not touch enable
    wr(1, 16'h8555);
    chk("R1 ena unaffected", ena_q, {1'b0, en_m[14:0]});

    // R2 request set/clear format
    wr(1, 16'h7FFF);
    chk("R2 clear all", req_q, 0);
    wr(1, 16'h8A05);
    chk("R2 set", req_q, 16'h0A05);
    wr(1, 16'h0801);
    chk("R2 clear sel", req_q, 16'h0204);
    // R3 request bit 14 never set
    wr(1, 16'hC000);
    chk("R3 req14 stays 0", req_q, 16'h0204);
    chk("R9 req bit15", req_q[15], 0);

    // R3 master off blocks all
    wr(0, 16'h7FFF);
    wr(0, 16'h BFFF);
    wr(1, 16'hBFFF);
    chk("R3 master off", irq_level, 0);
    wr(0, 16'hC000);
    chk("R3 master on", irq_level, 6);

    // R4 single enabled bit with all requested
    for (int b = 0; b < 14; b++) begin
      wr(0, 16'h3FFF);
      wr(0, 16'h8000 | (16'd1 << b));
      chk("R4 level map", irq_level, lvl(b));
    end

    // R5 pairs, all enabled
    wr(0, 16'hFFFF);
    for (int i = 0; i < 14; i++)
      for (int j = i + 1; j < 14; j++) begin
        wr(1, 16'h7FFF);
        wr(1, 16'h8000 | (16'd1 << i) | (16'd1 << j));
        chk("R5 highest", irq_level, (lvl(i) > lvl(j)) ? lvl(i) : lvl(j));
      end
    wr(1, 16'h7FFF);
    chk("R5 none", irq_level, 0);

    // R6 external high line
    @(negedge clk); ext_hi_n = 0;
    idle(2);
    chk("R6 not yet", req_q[13], 0);
    idle(1);
    chk("R6 set", req_q[13], 1);
    chk("R6 level", irq_level, 6);
    wr(1, 16'h2000);
    idle(5);
    chk("R6 once only", req_q[13], 0);
    ext_hi_n = 1; idle(4);
    ext_hi_n = 0; idle(3);
    chk("R6 new edge", req_q[13], 1);
    ext_hi_n = 1; wr(1, 16'h2000); idle(3);

    // R7 external low line
    ext_lo_n = 0;
    idle(2);
    chk("R7 not yet", req_q[3], 0);
    idle(1);
    chk("R7 set", req_q, 16'h0008);
    chk("R7 level", irq_level, 2);
    wr(1, 16'h0008);
    idle(5);
    chk("R7 once only", req_q[3], 0);
    ext_lo_n = 1; idle(3);

    // R8 pulses and set-wins
    @(negedge clk); src_pulse = 14'h0090;
    @(negedge clk); src_pulse = 0;
    chk("R8 pulse set", req_q, 16'h0090);
    wdata = 16'h0081; req_wr = 1; src_pulse = 14'h0001;
    @(negedge clk); req_wr = 0; src_pulse = 0;
    chk("R8 set wins", req_q, 16'h0011);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule